// File: doc/BRIEF.md
# ADC Sample and Sequence Controller

This controller decides when a successive-approximation converter samples and converts, and on which input channel. One of four trigger sources is picked: a one-cycle software request or one of three timer outputs. A timer source can be inverted before its rising edge is detected. An accepted trigger raises the sample-phase output. The phase lasts two synchronisation clocks plus a programmable sample count. The block then sends a one-cycle convert-start to the SAR engine and waits for its done pulse.

Four modes are supported: one channel converted once, a channel sequence converted once, one channel converted repeatedly, and a sequence converted repeatedly. A sequence starts at the selected channel and counts down to channel 0. When the multiple-sample option is set, only the first trigger is needed, and each later sample phase begins as soon as the previous conversion ends. A timer trigger in a once-only mode locks the block after it finishes. Only clearing and setting enable again unlocks it.

The controller states are IDLE, SYNC (two synchronisation clocks), SAMPLE (sample count), CONV_GO (convert-start pulse), CONV_WAIT (waiting for done), SEQ_WAIT (inside a sequence, waiting for the next trigger) and LOCKED (waiting for enable to drop). The transitions are:
- IDLE to SYNC on an accepted trigger.
- SYNC to SAMPLE when the synchronisation clocks have elapsed.
- SAMPLE to CONV_GO when the sample count expires.
- CONV_GO to CONV_WAIT after one cycle.
- CONV_WAIT, on done: to IDLE if enable is low. Otherwise to SYNC (multiple-sample set, more work left), to SEQ_WAIT (sequence not finished, multiple-sample clear), to LOCKED (timer-triggered once-only work finished) or to IDLE.
- SEQ_WAIT to SYNC on a trigger, or to IDLE if enable is low.
- LOCKED to IDLE when enable is low.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `trig_sel` picks the trigger source: 00 is `sw_start`, 01 is `timer_out[1]`, 10 is `timer_out[0]` and 11 is `timer_out[2]`. Unselected sources, and `sw_start` while a timer is selected, start nothing.
- R2: For timer sources, `trig_inv`=1 inverts the selected level before rising-edge detection, so a falling timer output starts a sample. `trig_inv` has no effect on `sw_start`.
- R3: A trigger accepted at a clock edge raises `sample` right after that edge. `sample` stays high for 2+N cycles, where `samp_time` 00=4, 01=8, 10=16 and 11=64 gives N.
- R4: `conv_start` is a one-cycle pulse in the cycle right after `sample` falls. It occurs at no other time.
- R5: `mode` 00 converts `chan_sel` once per trigger. `mode` 10 does the same but repeatedly. In both, `chan` equals `chan_sel` during conversion.
- R6: In sequence modes (`mode` 01 once, 11 repeated), successive conversions use `chan_sel`, `chan_sel`-1, ..., 0. The once mode ends after channel 0. The repeated mode begins again at `chan_sel`.
- R7: With `multi_samp`=0, every conversion needs its own trigger. With `multi_samp`=1, one trigger starts a sequence (or an endless repeat), and each later sample phase starts right after `sar_done`.
- R8: `sw_start` is a one-cycle request that counts only in a cycle where `enable` is high. It may be repeated in once-only modes without re-arming.
- R9: With a timer source in mode 00 or 01, triggers that arrive after the work finishes are ignored until `enable` has been low for at least one cycle and then set again.
- R10: `busy` is high during sample, convert-start and conversion, and between the conversions of an unfinished sequence. It is low in idle and while locked.
- R11: Clearing `enable` while busy lets the current conversion finish. The block then goes idle and issues no further `conv_start`.
- R12: After reset, `sample`, `conv_start` and `busy` are low and `chan` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | conversion clock |
| rst_n | input | 1 | active-low asynchronous reset |
| enable | input | 1 | conversion enable |
| sw_start | input | 1 | one-cycle software start request |
| trig_sel | input | 2 | trigger source select |
| trig_inv | input | 1 | timer trigger polarity invert |
| timer_out | input | 3 | timer compare outputs 0..2 |
| mode | input | 2 | conversion mode |
| multi_samp | input | 1 | automatic back-to-back sampling |
| samp_time | input | 2 | sample length select |
| chan_sel | input | CHAN_W | selected or highest channel |
| sar_done | input | 1 | SAR conversion complete pulse |
| chan | output | CHAN_W | channel being sampled or converted |
| sample | output | 1 | sample phase active |
| conv_start | output | 1 | convert-start pulse to SAR |
| busy | output | 1 | sample, conversion or sequence in progress |

## Verification
The main function is driven by a table of eight configurations. Together they cover every mode, every sample length, all four trigger sources and both polarities, with one to five triggers per row. Rows that send several triggers to a once-only mode show the difference between software starts, which repeat freely, and timer starts, which lock. Sequence rows with and without multiple-sample show whether the channel steps on one trigger or needs one trigger per step. The channel log and the `busy` level at the end of each row show where a sequence wraps or stops. Directed cases then cover unselected timers, software requests while disabled, the re-arm toggle, an enable drop mid-sequence and endless repetition.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int SYNC_CYC = 2;
    localparam int MAX_SAMP = 64;
    localparam int NUM_TMR  = 3;

    typedef enum logic [1:0] {
        MODE_ONE_ONCE = 2'b00,
        MODE_SEQ_ONCE = 2'b01,
        MODE_ONE_REP  = 2'b10,
        MODE_SEQ_REP  = 2'b11
    } conv_mode_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_SAMPLE,
        ST_CONV_GO,
        ST_CONV_WAIT,
        ST_SEQ_WAIT,
        ST_LOCKED
    } seq_state_t;

    function automatic int samp_clocks(input logic [1:0] sel);
        case (sel)
            2'b00:   return 4;
            2'b01:   return 8;
            2'b10:   return 16;
            default: return MAX_SAMP;
        endcase
    endfunction

endpackage

// File: rtl/adc_trig_front.sv
module adc_trig_front
    import adc_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               sw_start,
    input  logic [1:0]         trig_sel,
    input  logic               trig_inv,
    input  logic [NUM_TMR-1:0] timer_out,
    output logic               trig_evt,
    output logic               hw_src
);

    logic tmr_raw;
    logic tmr_pol;
    logic tmr_pol_q;

    // source decode
    always_comb begin
        unique case (trig_sel)
            2'b01:   tmr_raw = timer_out[1];
            2'b10:   tmr_raw = timer_out[0];
            2'b11:   tmr_raw = timer_out[2];
            default: tmr_raw = 1'b0;
        endcase
    end

    assign tmr_pol = tmr_raw ^ trig_inv;

    // previous level resets high so no edge is seen straight out of reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_pol_q <= 1'b1;
        else        tmr_pol_q <= tmr_pol;
    end

    assign hw_src   = (trig_sel != 2'b00);
    assign trig_evt = enable && (hw_src ? (tmr_pol && !tmr_pol_q) : sw_start);

endmodule

// File: rtl/adc_samp_timer.sv
module adc_samp_timer
    import adc_seq_pkg::*;
#(
    parameter int CNT_W = $clog2(SYNC_CYC + MAX_SAMP + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] samp_time,
    output logic       sync_last,
    output logic       samp_last
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (run) cnt <= cnt + CNT_W'(1);
        else          cnt <= '0;
    end

    assign sync_last = run && (cnt == CNT_W'(SYNC_CYC - 1));
    assign samp_last = run && (cnt == CNT_W'(SYNC_CYC + samp_clocks(samp_time) - 1));

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CHAN_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        mode,
    input  logic              multi_samp,
    input  logic [CHAN_W-1:0] chan_sel,
    input  logic              trig_evt,
    input  logic              hw_src,
    input  logic              sync_last,
    input  logic              samp_last,
    input  logic              sar_done,
    output logic [CHAN_W-1:0] chan,
    output logic              sample,
    output logic              conv_start,
    output logic              busy,
    output logic              timer_run
);

    seq_state_t        state, state_nxt;
    logic [CHAN_W-1:0] chan_nxt;
    logic              seq_mode;
    logic              rep_mode;
    logic              last_ch;

    assign seq_mode = mode[0];
    assign rep_mode = mode[1];
    assign last_ch  = !seq_mode || (chan == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            chan  <= '0;
        end else begin
            state <= state_nxt;
            chan  <= chan_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        chan_nxt  = chan;
        unique case (state)
            ST_IDLE: begin
                if (trig_evt) begin
                    state_nxt = ST_SYNC;
                    chan_nxt  = chan_sel;
                end
            end
            ST_SYNC:   if (sync_last) state_nxt = ST_SAMPLE;
            ST_SAMPLE: if (samp_last) state_nxt = ST_CONV_GO;
            ST_CONV_GO: state_nxt = ST_CONV_WAIT;
            ST_CONV_WAIT: begin
                if (sar_done) begin
                    if (!enable) begin
                        state_nxt = ST_IDLE;
                    end else if (last_ch) begin
                        if (rep_mode) begin
                            chan_nxt  = chan_sel;
                            state_nxt = multi_samp ? ST_SYNC : ST_IDLE;
                        end else begin
                            state_nxt = hw_src ? ST_LOCKED : ST_IDLE;
                        end
                    end else begin
                        chan_nxt  = chan - CHAN_W'(1);
                        state_nxt = multi_samp ? ST_SYNC : ST_SEQ_WAIT;
                    end
                end
            end
            ST_SEQ_WAIT: begin
                if (!enable)       state_nxt = ST_IDLE;
                else if (trig_evt) state_nxt = ST_SYNC;
            end
            ST_LOCKED: if (!enable) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sample     = (state == ST_SYNC) || (state == ST_SAMPLE);
        conv_start = (state == ST_CONV_GO);
        busy       = (state != ST_IDLE) && (state != ST_LOCKED);
        timer_run  = sample;
    end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int CHAN_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               sw_start,
    input  logic [1:0]         trig_sel,
    input  logic               trig_inv,
    input  logic [NUM_TMR-1:0] timer_out,
    input  logic [1:0]         mode,
    input  logic               multi_samp,
    input  logic [1:0]         samp_time,
    input  logic [CHAN_W-1:0]  chan_sel,
    input  logic               sar_done,
    output logic [CHAN_W-1:0]  chan,
    output logic               sample,
    output logic               conv_start,
    output logic               busy
);

    localparam int CNT_W = $clog2(SYNC_CYC + MAX_SAMP + 1);

    logic trig_evt;
    logic hw_src;
    logic timer_run;
    logic sync_last;
    logic samp_last;

    adc_trig_front u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .sw_start  (sw_start),
        .trig_sel  (trig_sel),
        .trig_inv  (trig_inv),
        .timer_out (timer_out),
        .trig_evt  (trig_evt),
        .hw_src    (hw_src)
    );

    adc_samp_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (timer_run),
        .samp_time (samp_time),
        .sync_last (sync_last),
        .samp_last (samp_last)
    );

    adc_seq_fsm #(.CHAN_W(CHAN_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .mode       (mode),
        .multi_samp (multi_samp),
        .chan_sel   (chan_sel),
        .trig_evt   (trig_evt),
        .hw_src     (hw_src),
        .sync_last  (sync_last),
        .samp_last  (samp_last),
        .sar_done   (sar_done),
        .chan       (chan),
        .sample     (sample),
        .conv_start (conv_start),
        .busy       (busy),
        .timer_run  (timer_run)
    );

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
    import adc_seq_pkg::*;
#(
    parameter int CHAN_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic [1:0]        samp_time,
    input logic [CHAN_W-1:0] chan,
    input logic              sample,
    input logic              conv_start,
    input logic              busy
);

    logic [7:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_len <= '0;
        else if (sample) run_len <= run_len + 8'd1;
        else             run_len <= '0;
    end

    // R3
    samp_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sample) |-> (run_len == 8'(SYNC_CYC + samp_clocks(samp_time))));

    // R4
    go_after_samp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sample) |-> conv_start);

    // R4
    go_needs_samp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(sample));

    // R4
    go_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R10
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample || conv_start) |-> busy);

    // R6
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && $past(sample)) |-> $stable(chan));

    // R8
    off_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !enable) |=> !sample);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CHAN_W(CHAN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .samp_time  (samp_time),
    .chan       (chan),
    .sample     (sample),
    .conv_start (conv_start),
    .busy       (busy)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;

    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          sw_start = 1'b0;
    logic [1:0]    trig_sel = 2'b00;
    logic          trig_inv = 1'b0;
    logic [2:0]    timer_out = 3'b000;
    logic [1:0]    mode = 2'b00;
    logic          multi_samp = 1'b0;
    logic [1:0]    samp_time = 2'b00;
    logic [CW-1:0] chan_sel = '0;
    logic          sar_done = 1'b0;
    logic [CW-1:0] chan;
    logic          sample;
    logic          conv_start;
    logic          busy;

    always #4 clk = ~clk;

    adc_seq_ctrl #(.CHAN_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sw_start(sw_start),
        .trig_sel(trig_sel), .trig_inv(trig_inv), .timer_out(timer_out),
        .mode(mode), .multi_samp(multi_samp), .samp_time(samp_time),
        .chan_sel(chan_sel), .sar_done(sar_done), .chan(chan),
        .sample(sample), .conv_start(conv_start), .busy(busy)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int n_conv   = 0;
    int len_bad  = 0;
    int ord_bad  = 0;
    int run_len  = 0;
    int exp_len  = 6;
    int dly      = 0;
    logic prev_samp = 1'b0;
    logic [CW-1:0] ch_log [0:255];

    // {samp_time, mode, multi_samp, chan_sel, trig_sel, trig_inv, n_trig, n_exp}
    localparam logic [21:0] VEC [8] = '{
        {2'd0, 2'd0, 1'b0, 4'd5, 2'd0, 1'b0, 4'd1, 6'd1},
        {2'd1, 2'd1, 1'b1, 4'd3, 2'd0, 1'b0, 4'd1, 6'd4},
        {2'd2, 2'd1, 1'b0, 4'd2, 2'd1, 1'b0, 4'd3, 6'd3},
        {2'd3, 2'd0, 1'b0, 4'd7, 2'd2, 1'b0, 4'd3, 6'd1},
        {2'd0, 2'd2, 1'b0, 4'd9, 2'd3, 1'b1, 4'd3, 6'd3},
        {2'd1, 2'd3, 1'b0, 4'd1, 2'd1, 1'b0, 4'd5, 6'd5},
        {2'd0, 2'd0, 1'b0, 4'd4, 2'd0, 1'b0, 4'd3, 6'd3},
        {2'd0, 2'd1, 1'b0, 4'd1, 2'd0, 1'b1, 4'd2, 6'd2}
    };

    function automatic int len_of(input logic [1:0] s);
        case (s)
            2'b00:   return 4;
            2'b01:   return 8;
            2'b10:   return 16;
            default: return 64;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // SAR model: done pulse a few cycles after each convert-start
    always @(negedge clk) begin
        sar_done = 1'b0;
        if (conv_start) dly = 3;
        else if (dly != 0) begin
            dly = dly - 1;
            if (dly == 0) sar_done = 1'b1;
        end
    end

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (sample) run_len++;
            if (prev_samp && !sample) begin
                if (run_len != exp_len) len_bad++;
                if (!conv_start) ord_bad++;
                run_len = 0;
            end
            if (conv_start) begin
                if (!prev_samp) ord_bad++;
                ch_log[n_conv % 256] = chan;
                n_conv++;
            end
            if ((sample || conv_start) && !busy) ord_bad++;
            prev_samp = sample;
        end
    end

    task automatic configure(input logic [1:0] st, input logic [1:0] md, input logic ms,
                             input logic [CW-1:0] cs, input logic [1:0] ts, input logic inv);
        @(negedge clk);
        enable     = 1'b0;
        samp_time  = st;
        mode       = md;
        multi_samp = ms;
        chan_sel   = cs;
        trig_sel   = ts;
        trig_inv   = inv;
        timer_out  = {3{inv}};
        exp_len    = 2 + len_of(st);
        repeat (3) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_tmr(input int idx);
        @(negedge clk);
        timer_out[idx] = ~trig_inv;
        repeat (3) @(negedge clk);
        timer_out[idx] = trig_inv;
    endtask

    task automatic fire();
        if (trig_sel == 2'b00) begin
            @(negedge clk);
            sw_start = 1'b1;
            @(negedge clk);
            sw_start = 1'b0;
        end else begin
            pulse_tmr(trig_sel == 2'b01 ? 1 : (trig_sel == 2'b10 ? 0 : 2));
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int base;
        int bad;
        repeat (3) @(negedge clk);
        #1;
        // R12 reset state
        chk(sample == 1'b0 && conv_start == 1'b0, "R12 sample/go", {sample, conv_start}, 0);
        chk(busy == 1'b0 && chan == '0, "R12 busy/chan", {busy, chan}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        settle(2);

        // table walk: R1 R2 R3 R5 R6 R7 R9 R10
        for (int v = 0; v < 8; v++) begin
            logic [21:0] e;
            int ntrig, nexp, cs, exp_last;
            logic [1:0] md;
            e = VEC[v];
            configure(e[21:20], e[19:18], e[17], e[16:13], e[12:11], e[10]);
            md = e[19:18];
            cs = int'(e[16:13]);
            ntrig = int'(e[9:6]);
            nexp = int'(e[5:0]);
            base = n_conv;
            for (int t = 0; t < ntrig; t++) begin
                fire();
                settle(150);
            end
            chk(n_conv - base == nexp, $sformatf("R5 R6 R7 R9 count vec%0d", v), n_conv - base, nexp);
            bad = 0;
            exp_last = cs;
            for (int k = 0; k < nexp; k++) begin
                int ex;
                ex = md[0] ? cs - (k % (cs + 1)) : cs;
                exp_last = ex;
                if (int'(ch_log[(base + k) % 256]) != ex) bad++;
            end
            chk(bad == 0, $sformatf("R5 R6 channels vec%0d", v), bad, 0);
            chk(busy == (md[0] && exp_last != 0), $sformatf("R10 busy vec%0d", v),
                busy, (md[0] && exp_last != 0));
            chk(len_bad == 0, $sformatf("R3 sample length vec%0d", v), len_bad, 0);
            chk(ord_bad == 0, $sformatf("R4 R10 order vec%0d", v), ord_bad, 0);
            @(negedge clk);
            enable = 1'b0;
            settle(5);
        end

        // R8 software request while disabled is ignored
        configure(2'd0, 2'd0, 1'b0, 4'd3, 2'd0, 1'b0);
        enable = 1'b0;
        base = n_conv;
        fire();
        settle(2);
        chk(busy == 1'b0, "R8 disabled sw busy", busy, 0);
        settle(40);
        chk(n_conv == base, "R8 disabled sw ignored", n_conv - base, 0);

        // R1 unselected timers and sw_start ignored with timer 1 selected
        configure(2'd0, 2'd2, 1'b0, 4'd6, 2'd1, 1'b0);
        base = n_conv;
        pulse_tmr(0);
        pulse_tmr(2);
        @(negedge clk);
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        settle(60);
        chk(n_conv == base, "R1 unselected sources", n_conv - base, 0);
        pulse_tmr(1);
        settle(60);
        chk(n_conv == base + 1, "R1 selected timer", n_conv - base, 1);

        // R2 inversion: rising edge of the raw timer does not start when inverted
        configure(2'd0, 2'd2, 1'b0, 4'd6, 2'd1, 1'b1);
        base = n_conv;
        @(negedge clk);
        timer_out[1] = 1'b0;
        settle(60);
        chk(n_conv == base + 1, "R2 falling edge starts", n_conv - base, 1);
        @(negedge clk);
        timer_out[1] = 1'b1;
        settle(60);
        chk(n_conv == base + 1, "R2 rising edge ignored", n_conv - base, 1);

        // R9 re-arm by enable toggle
        configure(2'd0, 2'd0, 1'b0, 4'd2, 2'd1, 1'b0);
        base = n_conv;
        fire();
        settle(60);
        chk(n_conv == base + 1, "R9 first timer start", n_conv - base, 1);
        fire();
        settle(60);
        chk(n_conv == base + 1, "R9 locked ignores", n_conv - base, 1);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
        fire();
        settle(60);
        chk(n_conv == base + 2, "R9 rearmed", n_conv - base, 2);

        // R11 enable dropped mid-sequence
        configure(2'd0, 2'd3, 1'b1, 4'd5, 2'd0, 1'b0);
        base = n_conv;
        fire();
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            #1;
            if (n_conv - base >= 2) break;
        end
        enable = 1'b0;
        settle(2);
        chk(busy == 1'b1, "R11 conversion finishing", busy, 1);
        settle(40);
        chk(n_conv - base == 2 && busy == 1'b0, "R11 stop after current", n_conv - base, 2);

        // R7 repeated single channel with automatic resampling
        configure(2'd0, 2'd2, 1'b1, 4'd6, 2'd0, 1'b0);
        base = n_conv;
        fire();
        settle(250);
        chk(n_conv - base >= 12, "R7 automatic repeats", n_conv - base, 12);
        bad = 0;
        for (int k = base; k < n_conv; k++) if (ch_log[k % 256] != 4'd6) bad++;
        chk(bad == 0, "R5 repeated channel", bad, 0);
        @(negedge clk);
        enable = 1'b0;
        settle(40);
        chk(busy == 1'b0, "R11 repeat stopped", busy, 0);
        chk(len_bad == 0 && ord_bad == 0, "R3 R4 overall timing", len_bad + ord_bad, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule